// File: doc/BRIEF.md
# Chopped Multichannel Conversion Sequencer

This block is the timing controller for a multiplexed sigma-delta converter. It walks through the enabled input channels in ascending order and wraps around. For each channel it runs a phase sequence counted in master-clock cycles. It drives the multiplexer select, the input polarity (chop) control and a half-rate modulator sample strobe. It captures the filter results the surrounding logic supplies and writes a scaled result into the channel data register. The calibration arithmetic is modelled as a pass-through whose latency is the scaling phase.

Each channel has its own sampling length and its own chop setting, and both are latched when that channel's cycle starts. The states are:

- `ST_IDLE`: no channel enabled.
- `ST_SETTLE_A`: first settle after the multiplexer moves.
- `ST_SAMPLE_A`: first sample window.
- `ST_SETTLE_B`: second settle, polarity reversed.
- `ST_SAMPLE_B`: second sample window, polarity reversed.
- `ST_SCALE`: scaling.

The transitions are:

- IDLE→SETTLE_A when an enabled channel exists.
- SETTLE_A→SAMPLE_A when the settle count ends.
- SAMPLE_A→SETTLE_B when the window ends and chop is on.
- SAMPLE_A→SCALE when the window ends and chop is off.
- SETTLE_B→SAMPLE_B when the settle count ends.
- SAMPLE_B→SCALE when the window ends.
- SCALE→SETTLE_A at the end of scaling, with the next enabled channel.
- SCALE→IDLE at the end of scaling, when no channel is left enabled.

A combined ready line is high during scaling and while idle. A sticky per-channel ready flag is set by every data write and cleared by a host read of that channel.

Top module: `conv_seq`

## Requirements
- R1: While reset is asserted, `rdy_line` is 1, and `wr_stb`, `samp_stb`, `chop_inv` and all of `chan_rdy` are 0.
- R2: Channels are converted in ascending index order, with wraparound, and channels whose `chan_en` bit is 0 are skipped. The first channel converted after reset is the lowest enabled index. `wr_chan` carries the index of the channel just finished.
- R3: The first settle phase lasts 43 cycles when `settle_long`=0 and 44 cycles when it is 1. `rdy_line` is 0 throughout it.
- R4: A sample window lasts 2·(L+1) cycles, where L is the channel's 4-bit field `chan_len[4c+3:4c]`. `samp_stb` pulses on the first cycle of the window and on every second cycle after it, giving L+1 pulses per window.
- R5: When the channel's `chan_chop` bit is 1, the first window is followed by a 42-cycle settle and then a second window of the same length. `chop_inv` is 1 in exactly those two phases, so for 42+2·(L+1) cycles.
- R6: The scaling phase lasts 163 cycles with `rdy_line`=1. The cycles per conversion with `rdy_line`=0 are settle+2(L+1) without chop, and settle+2(L+1)+42+2(L+1) with chop.
- R7: `wr_stb` is a one-cycle pulse in the first cycle after scaling ends. `rdy_line` falls in that same cycle if another channel follows.
- R8: `wr_data` is `res_a` without chop. With chop it is (`res_a`−`res_b`) arithmetically shifted right by one, in two's complement. `res_a` is taken on the last cycle of the first window and `res_b` on the last cycle of the second.
- R9: `chan_rdy[c]` is 1 from the `wr_stb` cycle for channel c onward. It is cleared on the edge after a cycle with `rd_stb`=1 and `rd_chan`=c. A set and a clear on the same edge leave the flag at 1.
- R10: With `chan_en` all zero the block stays idle: `rdy_line` stays 1 and no `samp_stb` or `wr_stb` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Channel enable mask |
| chan_chop | input | NCH | Per-channel chop mode |
| chan_len | input | NCH*LW | Per-channel sampling length fields, channel c at [LW*c +: LW] |
| settle_long | input | 1 | Selects the 44-cycle first settle |
| res_a | input | DW | Filter result of the first window (signed) |
| res_b | input | DW | Filter result of the reversed window (signed) |
| rd_stb | input | 1 | Host read of a channel data register |
| rd_chan | input | IW | Channel being read |
| mux_sel | output | IW | Multiplexer channel select |
| chop_inv | output | 1 | Input polarity reversed |
| samp_stb | output | 1 | Half-rate modulator sample strobe |
| rdy_line | output | 1 | Combined ready line, high in scaling and idle |
| wr_stb | output | 1 | Channel data register write |
| wr_chan | output | IW | Channel being written |
| wr_data | output | DW | Data written |
| chan_rdy | output | NCH | Per-channel ready flags |

## Verification
A write that sets a channel's flag and a host read that clears the same flag can land on the same clock edge. The bench provokes this by holding a read of one channel for a whole run, so every write to that channel meets a pending clear. In the write cycle the flag must read 1, and one cycle later it must read 0. The bench also sweeps every enable mask with both settle lengths and varying chop masks and lengths. For each conversion it recomputes the phase lengths, strobe counts and result arithmetically.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE_A,
        ST_SAMPLE_A,
        ST_SETTLE_B,
        ST_SAMPLE_B,
        ST_SCALE
    } seq_state_t;
endpackage

// File: rtl/chan_picker.sv
module chan_picker #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [IW-1:0]  cur,
    input  logic [NCH-1:0] en,
    output logic [IW-1:0]  nxt,
    output logic           found
);
    // search cur+1, cur+2, ... cur (wrap), first enabled wins
    always_comb begin
        found = 1'b0;
        nxt   = cur;
        for (int k = 1; k <= NCH; k++) begin
            int idx;
            idx = (int'(cur) + k) % NCH;
            if (!found && en[idx]) begin
                found = 1'b1;
                nxt   = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/rdy_flags.sv
module rdy_flags #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_stb,
    input  logic [IW-1:0]  set_idx,
    input  logic           clr_stb,
    input  logic [IW-1:0]  clr_idx,
    output logic [NCH-1:0] flags
);
    for (genvar c = 0; c < NCH; c++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[c] <= 1'b0;
            else if (set_stb && set_idx == IW'(c))
                flags[c] <= 1'b1;      // new data beats a read
            else if (clr_stb && clr_idx == IW'(c))
                flags[c] <= 1'b0;
        end
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> flags[$past(set_idx)]);
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int NCH          = 4,
    parameter int LW           = 4,
    parameter int DW           = 16,
    parameter int SETTLE_SHORT = 43,
    parameter int SETTLE_LONG  = 44,
    parameter int CHOP_SETTLE  = 42,
    parameter int SCALE_CYC    = 163,
    parameter int IW           = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH-1:0]    chan_chop,
    input  logic [NCH*LW-1:0] chan_len,
    input  logic              settle_long,
    input  logic [DW-1:0]     res_a,
    input  logic [DW-1:0]     res_b,
    input  logic              rd_stb,
    input  logic [IW-1:0]     rd_chan,
    output logic [IW-1:0]     mux_sel,
    output logic              chop_inv,
    output logic              samp_stb,
    output logic              rdy_line,
    output logic              wr_stb,
    output logic [IW-1:0]     wr_chan,
    output logic [DW-1:0]     wr_data,
    output logic [NCH-1:0]    chan_rdy
);
    localparam int WIN_MAX = 2 ** (LW + 1);
    localparam int T_A     = (SCALE_CYC > WIN_MAX) ? SCALE_CYC : WIN_MAX;
    localparam int T_MAX   = (T_A > SETTLE_LONG) ? T_A : SETTLE_LONG;
    localparam int CW      = $clog2(T_MAX + 1);

    seq_state_t       state, st_n;
    logic [CW-1:0]    cnt, cnt_n;
    logic [IW-1:0]    cur, cur_n, pick;
    logic             found, start, fire;
    logic             cur_chop;
    logic [LW-1:0]    cur_len;
    logic [DW-1:0]    cap_a, cap_b;
    logic [CW-1:0]    win_m1, settle_m1;
    logic signed [DW:0] diff;
    logic [CW-1:0]    scale_run;

    chan_picker #(.NCH(NCH), .IW(IW)) u_pick (
        .cur(cur), .en(chan_en), .nxt(pick), .found(found)
    );

    rdy_flags #(.NCH(NCH), .IW(IW)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_stb(fire), .set_idx(cur),
        .clr_stb(rd_stb), .clr_idx(rd_chan),
        .flags(chan_rdy)
    );

    assign win_m1    = CW'({cur_len, 1'b1});   // 2*(L+1)-1
    assign settle_m1 = settle_long ? CW'(SETTLE_LONG - 1) : CW'(SETTLE_SHORT - 1);
    assign diff      = $signed({cap_a[DW-1], cap_a}) - $signed({cap_b[DW-1], cap_b});

    // next state and counter load
    always_comb begin
        st_n  = state;
        cnt_n = (cnt != '0) ? cnt - 1'b1 : cnt;
        cur_n = cur;
        start = 1'b0;
        fire  = 1'b0;
        unique case (state)
            ST_IDLE: if (found) begin
                st_n = ST_SETTLE_A; cur_n = pick; cnt_n = settle_m1; start = 1'b1;
            end
            ST_SETTLE_A: if (cnt == '0) begin
                st_n = ST_SAMPLE_A; cnt_n = win_m1;
            end
            ST_SAMPLE_A: if (cnt == '0) begin
                if (cur_chop) begin
                    st_n = ST_SETTLE_B; cnt_n = CW'(CHOP_SETTLE - 1);
                end else begin
                    st_n = ST_SCALE; cnt_n = CW'(SCALE_CYC - 1);
                end
            end
            ST_SETTLE_B: if (cnt == '0) begin
                st_n = ST_SAMPLE_B; cnt_n = win_m1;
            end
            ST_SAMPLE_B: if (cnt == '0) begin
                st_n = ST_SCALE; cnt_n = CW'(SCALE_CYC - 1);
            end
            ST_SCALE: if (cnt == '0) begin
                fire = 1'b1;
                if (found) begin
                    st_n = ST_SETTLE_A; cur_n = pick; cnt_n = settle_m1; start = 1'b1;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur      <= IW'(NCH - 1);
            cur_chop <= 1'b0;
            cur_len  <= '0;
            cap_a    <= '0;
            cap_b    <= '0;
            wr_stb   <= 1'b0;
            wr_chan  <= '0;
            wr_data  <= '0;
        end else begin
            state  <= st_n;
            cnt    <= cnt_n;
            cur    <= cur_n;
            wr_stb <= fire;
            if (start) begin
                cur_chop <= chan_chop[cur_n];
                cur_len  <= chan_len[cur_n*LW +: LW];
            end
            if (state == ST_SAMPLE_A && cnt == '0) cap_a <= res_a;
            if (state == ST_SAMPLE_B && cnt == '0) cap_b <= res_b;
            if (fire) begin
                wr_chan <= cur;
                wr_data <= cur_chop ? diff[DW:1] : cap_a;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        mux_sel  = cur;
        rdy_line = (state == ST_SCALE) || (state == ST_IDLE);
        chop_inv = (state == ST_SETTLE_B) || (state == ST_SAMPLE_B);
        samp_stb = ((state == ST_SAMPLE_A) || (state == ST_SAMPLE_B)) && cnt[0];
    end

    // checker counter: cycles spent in the current scaling phase
    always_ff @(posedge clk) begin
        if (!rst_n)                 scale_run <= '0;
        else if (state == ST_SCALE) scale_run <= scale_run + 1'b1;
        else                        scale_run <= '0;
    end

    a_r4_strobe_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |=> !samp_stb);
    a_r4_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |-> !rdy_line);
    a_r6_scale_length: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> scale_run == CW'(SCALE_CYC));
    a_r7_write_after_scale: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(rdy_line) && !$past(wr_stb));
    a_r9_flag_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> chan_rdy[wr_chan]);
endmodule

// File: tb/sim_conv_seq.sv
module sim_conv_seq;
    localparam int NCH = 4;
    localparam int LW  = 4;
    localparam int DW  = 16;
    localparam int IW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]    chan_en = '0, chan_chop = '0;
    logic [NCH*LW-1:0] chan_len = '0;
    logic settle_long = 1'b0;
    logic [DW-1:0] res_a = '0, res_b = '0;
    logic rd_stb = 1'b0;
    logic [IW-1:0] rd_chan = '0;
    logic [IW-1:0] mux_sel, wr_chan;
    logic chop_inv, samp_stb, rdy_line, wr_stb;
    logic [DW-1:0] wr_data;
    logic [NCH-1:0] chan_rdy;

    always #5 clk = ~clk;

    conv_seq u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_chop(chan_chop),
        .chan_len(chan_len), .settle_long(settle_long), .res_a(res_a), .res_b(res_b),
        .rd_stb(rd_stb), .rd_chan(rd_chan), .mux_sel(mux_sel), .chop_inv(chop_inv),
        .samp_stb(samp_stb), .rdy_line(rdy_line), .wr_stb(wr_stb), .wr_chan(wr_chan),
        .wr_data(wr_data), .chan_rdy(chan_rdy)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    bit mon_on = 0;
    bit rd_hold = 0;
    bit prev_hit = 0;
    int lcnt, hcnt, scnt, ccnt, nconv;
    int exp_prev;

    function automatic int next_en(input int prev, input logic [NCH-1:0] m);
        for (int k = 1; k <= NCH; k++)
            if (m[(prev + k) % NCH]) return (prev + k) % NCH;
        return -1;
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            if (rd_hold && prev_hit)
                check(chan_rdy[rd_chan] == 1'b0, "R9 clear after coincident set", chan_rdy[rd_chan], 0);
            prev_hit = 0;
            if (wr_stb) begin
                int ch, L, w, st, ch_exp_l, exp_d, da, db;
                ch = next_en(exp_prev, chan_en);
                check(int'(wr_chan) == ch, "R2 channel order", wr_chan, ch);
                L  = int'(chan_len[ch*LW +: LW]);
                w  = 2 * (L + 1);
                st = settle_long ? 44 : 43;
                ch_exp_l = st + w + (chan_chop[ch] ? 42 + w : 0);
                check(lcnt == ch_exp_l, "R3 R6 low cycles", lcnt, ch_exp_l);
                check(hcnt == 163, "R6 scaling cycles", hcnt, 163);
                check(scnt == (L + 1) * (chan_chop[ch] ? 2 : 1), "R4 strobe count",
                      scnt, (L + 1) * (chan_chop[ch] ? 2 : 1));
                check(ccnt == (chan_chop[ch] ? 42 + w : 0), "R5 reversed cycles",
                      ccnt, chan_chop[ch] ? 42 + w : 0);
                da = int'($signed(res_a));
                db = int'($signed(res_b));
                exp_d = chan_chop[ch] ? ((da - db) >>> 1) : da;
                check(wr_data == DW'(exp_d), "R8 data", wr_data, int'(DW'(exp_d)));
                check(chan_rdy[ch] == 1'b1, "R9 flag set in write cycle", chan_rdy[ch], 1);
                check(!rdy_line, "R7 rdy falls with write", rdy_line, 0);
                if (rd_hold && ch == int'(rd_chan)) prev_hit = 1;
                exp_prev = ch;
                nconv++;
                lcnt = 0; hcnt = 0; scnt = 0; ccnt = 0;
            end
            if (!rdy_line) lcnt++;
            else if (lcnt > 0) hcnt++;
            if (samp_stb) scnt++;
            if (chop_inv) ccnt++;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_cfg(input int i, input int sl, input bit hold);
        logic [NCH-1:0] m;
        int target, guard;
        @(negedge clk);
        mon_on = 0;
        rst_n = 0;
        m = NCH'(i);
        chan_en = m;
        chan_chop = NCH'(i * 5 + sl * 3);
        for (int c = 0; c < NCH; c++)
            chan_len[c*LW +: LW] = LW'((i + 4 * c + sl * 7) % 16);
        settle_long = sl[0];
        res_a = DW'(i * 3001 - 20000 + sl * 17);
        res_b = DW'(9000 - i * 1777 - sl * 5);
        rd_hold = hold;
        rd_stb = hold;
        rd_chan = (m[2]) ? 2'd2 : 2'd0;
        repeat (3) @(negedge clk);
        check(rdy_line == 1'b1 && wr_stb == 1'b0 && samp_stb == 1'b0 && chop_inv == 1'b0,
              "R1 reset outputs", {rdy_line, wr_stb, samp_stb, chop_inv}, 4'b1000);
        check(chan_rdy == '0, "R1 reset flags", chan_rdy, 0);
        lcnt = 0; hcnt = 0; scnt = 0; ccnt = 0; nconv = 0;
        exp_prev = NCH - 1;
        prev_hit = 0;
        rst_n = 1;
        mon_on = 1;
        if (m == '0) begin
            repeat (500) @(negedge clk);
            check(nconv == 0 && lcnt == 0 && scnt == 0 && rdy_line,
                  "R10 idle with no channel", nconv + lcnt + scnt, 0);
        end else begin
            target = 2 * $countones(m) + 1;
            guard = 0;
            while (nconv < target && guard < 4000) begin
                @(negedge clk);
                guard++;
            end
            check(nconv >= target, "R2 conversions completed", nconv, target);
            if (!hold)
                check(chan_rdy == m, "R9 flags after scan", chan_rdy, m);
        end
        mon_on = 0;
        rd_stb = 0;
        rd_hold = 0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        for (int i = 0; i < 16; i++)
            for (int sl = 0; sl < 2; sl++)
                run_cfg(i, sl, 1'b0);
        // coincident set/clear on channel 2 with several patterns
        run_cfg(4'b0100, 0, 1'b1);
        run_cfg(4'b0101, 1, 1'b1);
        run_cfg(4'b1111, 0, 1'b1);
        // single read clears one flag (R9)
        run_cfg(4'b0011, 0, 1'b0);
        @(negedge clk);
        rd_stb = 1; rd_chan = 2'd0;
        @(negedge clk);
        rd_stb = 0;
        check(chan_rdy[0] == 1'b0 || wr_stb, "R9 read clears flag", chan_rdy[0], 0);
        check(chan_rdy[1] == 1'b1, "R9 other flag kept", chan_rdy[1], 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule